// File: doc/BRIEF.md
# Overcurrent Interrupt Message Latch

This block collects overcurrent events from a sixteen-channel output driver and holds them as sticky message bits. Software sees them through two 8-bit read-only message registers and an active-low interrupt line. A new message is recorded when a channel's overcurrent flag rises while that channel's interrupt enable is set and the channel is in output mode.

A read of either message register freezes both registers so that software sees a consistent snapshot. Events that occur while the registers are frozen are collected in a one-deep hold stage. The end-of-interrupt (EOI) command unfreezes the registers and loads them from the hold stage. When the hold stage is empty, this clears them. If events arrived during the freeze, the interrupt line therefore stays low after EOI.

Control is a two-state machine. OPEN is the state in which message updates land directly in the registers. FROZEN is the state in which updates go to the hold stage. The transitions are FREEZE (OPEN to FROZEN on a register read), RELEASE (FROZEN to OPEN on EOI) and IDLE_ACK (OPEN to OPEN on EOI).

Top module: `ocm_msg_latch`

## Requirements
- R1: After reset both message registers read 0x00, the hold stage is empty, the state is OPEN and the interrupt line is high.
- R2: A rising edge of a channel's overcurrent flag (low in one sampled cycle, high in the next) sets that channel's message bit when its enable is 1. Channel k (1..16) maps to bit k-1 of the low register for k ≤ 8 and to bit k-9 of the high register for k ≥ 9. A flag held high records nothing more.
- R3: An overcurrent edge on a channel whose enable is 0 records no message.
- R4: A read strobe whose address is 0x06 (low register) or 0x07 (high register) freezes the registers. A strobe at any other address has no effect.
- R5: While the registers are FROZEN, and in the cycle of the freezing read itself, new events go to the hold stage and the visible registers do not change.
- R6: The hold stage collects every event that arrives during the freeze by bitwise OR.
- R7: EOI returns the state to OPEN, loads the registers with the hold stage together with any event of the same cycle, and empties the hold stage. With an empty hold stage it clears the registers.
- R8: The interrupt line is low when any channel in output mode has a message bit set in the registers or in the hold stage, and high otherwise.
- R9: A channel whose enable goes from 0 to 1 has its message bit cleared in both the registers and the hold stage. This clear wins over an event in the same cycle.
- R10: A channel whose mode bit is 1 (input mode) reads its message bit as 0 and records no new events. A bit stored earlier is kept and reappears when the channel returns to output mode.
- R11: EOI in the same cycle as a qualifying read takes priority. The state ends in OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_flag_i | input | 16 | Per-channel overcurrent flag, level, bit k-1 = channel k |
| irq_en_i | input | 16 | Per-channel interrupt enable |
| in_mode_i | input | 16 | Per-channel mode, 1 = input, 0 = output |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| eoi_i | input | 1 | End-of-interrupt command |
| msg_lo_o | output | 8 | Message register, channels 1..8 |
| msg_hi_o | output | 8 | Message register, channels 9..16 |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Two kinds of cycle collision are driven on purpose. The first pairs an event with the read that freezes the registers: a new flag edge is driven in the same cycle as a read of 0x06, and the bench expects the bit to be absent from the frozen registers and to appear only after the following EOI. The second pairs EOI with an event, and separately EOI with a read: the event bit is expected directly in the registers, and a subsequent event is expected to show up at once because the state is OPEN. The bench reference model applies the priorities from the requirements every cycle, and each visible register byte and the interrupt line are compared against it on the following falling edge.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_FROZEN = 1'b1
    } ocm_state_e;

endpackage

// File: rtl/ocm_edge_detect.sv
module ocm_edge_detect #(
    parameter int NUM_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] oc_flag_i,
    input  logic [NUM_CH-1:0] irq_en_i,
    input  logic [NUM_CH-1:0] in_mode_i,
    output logic [NUM_CH-1:0] event_o,
    output logic [NUM_CH-1:0] rearm_o
);

    logic [NUM_CH-1:0] oc_q;
    logic [NUM_CH-1:0] en_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                oc_q[ch] <= 1'b0;
                en_q[ch] <= 1'b0;
            end else begin
                oc_q[ch] <= oc_flag_i[ch];
                en_q[ch] <= irq_en_i[ch];
            end
        end

        // new message: flag edge on an enabled output-mode channel
        assign event_o[ch] = oc_flag_i[ch] & ~oc_q[ch] & irq_en_i[ch] & ~in_mode_i[ch];
        // enable re-armed: clear this channel's message
        assign rearm_o[ch] = irq_en_i[ch] & ~en_q[ch];
    end

endmodule

// File: rtl/ocm_ctrl.sv
module ocm_ctrl
    import ocm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rd_hit_i,
    input  logic eoi_i,
    output logic frozen_o,
    output logic to_hold_o,
    output logic load_o
);

    ocm_state_e state_q;
    ocm_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: FREEZE, RELEASE, IDLE_ACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (eoi_i) begin
                    state_d = ST_OPEN;      // IDLE_ACK
                end else if (rd_hit_i) begin
                    state_d = ST_FROZEN;    // FREEZE
                end
            end
            ST_FROZEN: begin
                if (eoi_i) begin
                    state_d = ST_OPEN;      // RELEASE
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        frozen_o  = 1'b0;
        to_hold_o = 1'b0;
        load_o    = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                load_o    = eoi_i;
                to_hold_o = rd_hit_i & ~eoi_i;
            end
            ST_FROZEN: begin
                frozen_o  = 1'b1;
                load_o    = eoi_i;
                to_hold_o = ~eoi_i;
            end
            default: begin
                frozen_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ocm_msg_store.sv
module ocm_msg_store #(
    parameter int NUM_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] event_i,
    input  logic [NUM_CH-1:0] rearm_i,
    input  logic              to_hold_i,
    input  logic              load_i,
    output logic [NUM_CH-1:0] msg_o,
    output logic [NUM_CH-1:0] hold_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
        logic msg_q, hold_q, msg_d, hold_d;

        always_comb begin
            msg_d  = msg_q;
            hold_d = hold_q;
            if (load_i) begin
                msg_d  = hold_q | event_i[ch];
                hold_d = 1'b0;
            end else if (to_hold_i) begin
                hold_d = hold_q | event_i[ch];
            end else begin
                msg_d  = msg_q | event_i[ch];
            end
            if (rearm_i[ch]) begin
                msg_d  = 1'b0;
                hold_d = 1'b0;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                msg_q  <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                msg_q  <= msg_d;
                hold_q <= hold_d;
            end
        end

        assign msg_o[ch]  = msg_q;
        assign hold_o[ch] = hold_q;
    end

endmodule

// File: rtl/ocm_msg_latch.sv
module ocm_msg_latch #(
    parameter int          NUM_CH   = 16,
    parameter int          REG_W    = 8,
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  MSG_BASE = 8'h06
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [15:0]       oc_flag_i,
    input  logic [15:0]       irq_en_i,
    input  logic [15:0]       in_mode_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              eoi_i,
    output logic [REG_W-1:0]  msg_lo_o,
    output logic [REG_W-1:0]  msg_hi_o,
    output logic              irq_n_o
);

    localparam int NUM_REG = NUM_CH / REG_W;

    logic [NUM_CH-1:0] ev;
    logic [NUM_CH-1:0] rearm;
    logic [NUM_CH-1:0] msg_q;
    logic [NUM_CH-1:0] hold_q;
    logic [NUM_CH-1:0] visible;
    logic              rd_hit;
    logic              frozen;
    logic              to_hold;
    logic              load;

    assign rd_hit = rd_stb_i
                  && (rd_addr_i >= ADDR_W'(MSG_BASE))
                  && (rd_addr_i <  ADDR_W'(MSG_BASE) + ADDR_W'(NUM_REG));

    ocm_edge_detect #(.NUM_CH(NUM_CH)) u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .oc_flag_i (oc_flag_i),
        .irq_en_i  (irq_en_i),
        .in_mode_i (in_mode_i),
        .event_o   (ev),
        .rearm_o   (rearm)
    );

    ocm_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_hit_i  (rd_hit),
        .eoi_i     (eoi_i),
        .frozen_o  (frozen),
        .to_hold_o (to_hold),
        .load_o    (load)
    );

    ocm_msg_store #(.NUM_CH(NUM_CH)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .event_i   (ev),
        .rearm_i   (rearm),
        .to_hold_i (to_hold),
        .load_i    (load),
        .msg_o     (msg_q),
        .hold_o    (hold_q)
    );

    assign visible  = msg_q & ~in_mode_i;
    assign msg_lo_o = visible[REG_W-1:0];
    assign msg_hi_o = visible[2*REG_W-1:REG_W];
    assign irq_n_o  = ~|((msg_q | hold_q) & ~in_mode_i);

endmodule

// File: rtl/ocm_msg_latch_chk.sv
module ocm_msg_latch_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              eoi_i,
    input logic [NUM_CH-1:0] in_mode_i,
    input logic              rd_hit,
    input logic              frozen,
    input logic [NUM_CH-1:0] rearm,
    input logic [NUM_CH-1:0] msg_q,
    input logic [NUM_CH-1:0] hold_q,
    input logic              irq_n_o
);

    // R5
    frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frozen && !eoi_i && rearm == '0) |=> $stable(msg_q));

    // R4
    freeze_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frozen) |-> $past(rd_hit));

    // R6
    hold_only_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_q != '0) |-> frozen);

    // R7
    eoi_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoi_i |=> (hold_q == '0 && !frozen));

    // R8
    eoi_irq_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_i && ((hold_q & ~in_mode_i) != '0) && rearm == '0)
        |=> (!irq_n_o || !$stable(in_mode_i)));

    // R9
    rearm_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rearm != '0) |=> (((msg_q | hold_q) & $past(rearm)) == '0));

endmodule

bind ocm_msg_latch ocm_msg_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoi_i     (eoi_i),
    .in_mode_i (in_mode_i),
    .rd_hit    (rd_hit),
    .frozen    (frozen),
    .rearm     (rearm),
    .msg_q     (msg_q),
    .hold_q    (hold_q),
    .irq_n_o   (irq_n_o)
);

// File: tb/tb_ocm_msg_latch.sv
module tb_ocm_msg_latch;

    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        string       tag;
        logic [15:0] msg;
        logic [15:0] hold;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] oc = '0, en = '0, inm = '0;
    logic        rd = 1'b0, eoi = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  lo, hi;
    logic        irq_n;

    int errors = 0;
    int checks = 0;
    item_t q[$];

    // reference model state
    logic [15:0] m_msg = '0, m_hold = '0, m_oc_q = '0, m_en_q = '0;
    logic        m_frozen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocm_msg_latch dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .oc_flag_i (oc),
        .irq_en_i  (en),
        .in_mode_i (inm),
        .rd_stb_i  (rd),
        .rd_addr_i (addr),
        .eoi_i     (eoi),
        .msg_lo_o  (lo),
        .msg_hi_o  (hi),
        .irq_n_o   (irq_n)
    );

    // driver: apply one cycle of stimulus, model it, push the expectation
    task automatic step(input string tag, input logic r, input logic [7:0] a, input logic e);
        logic [15:0] ev, rearm;
        logic        hit;
        item_t       it;
        rd = r; addr = a; eoi = e;
        @(posedge clk);
        ev    = oc & ~m_oc_q & en & ~inm;
        rearm = en & ~m_en_q;
        hit   = r && (a == 8'h06 || a == 8'h07);
        if (e) begin
            m_msg = m_hold | ev; m_hold = '0; m_frozen = 1'b0;
        end else if (m_frozen || hit) begin
            m_hold = m_hold | ev; m_frozen = 1'b1;
        end else begin
            m_msg = m_msg | ev;
        end
        m_msg  = m_msg & ~rearm;
        m_hold = m_hold & ~rearm;
        m_oc_q = oc; m_en_q = en;
        it.tag = tag; it.msg = m_msg; it.hold = m_hold;
        q.push_back(it);
        #1;
        rd = 1'b0; eoi = 1'b0;
    endtask

    // monitor: compare on the falling edge, masking with the live mode bits
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t       it;
            logic [15:0] vis;
            logic        exp_irq;
            it      = q.pop_front();
            vis     = it.msg & ~inm;
            exp_irq = ~|((it.msg | it.hold) & ~inm);
            checks++;
            if (lo !== vis[7:0] || hi !== vis[15:8] || irq_n !== exp_irq) begin
                errors++;
                $display("FAIL %s: lo=%h hi=%h irq_n=%b expected lo=%h hi=%h irq_n=%b",
                         it.tag, lo, hi, irq_n, vis[7:0], vis[15:8], exp_irq);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        checks++;
        if (lo !== 8'h00 || hi !== 8'h00 || irq_n !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: lo=%h hi=%h irq_n=%b expected 00 00 1", lo, hi, irq_n);
        end
        @(posedge clk); #1 rst_n = 1'b1;

        en = 16'hFFFF;           step("R1 idle after reset", 0, 8'h00, 0);
        oc = 16'h0001;           step("R2 ch1 edge", 0, 8'h00, 0);
                                 step("R2 level held", 0, 8'h00, 0);
        oc = 16'h0000; en = 16'hFFFD; step("R3 setup", 0, 8'h00, 0);
        oc = 16'h0002;           step("R3 disabled ch2", 0, 8'h00, 0);
        oc = 16'h0100;           step("R2 ch9 high reg", 0, 8'h00, 0);
        oc = 16'h0000;           step("R4 other address", 1, 8'h05, 0);
        oc = 16'h0004;           step("R5 event with freezing read", 1, 8'h06, 0);
        oc = 16'h0014;           step("R5 event while frozen", 0, 8'h00, 0);
        oc = 16'h8014;           step("R6 hold OR ch16", 0, 8'h00, 0);
                                 step("R8 frozen with hold", 0, 8'h00, 0);
                                 step("R7 eoi loads hold", 0, 8'h00, 1);
        oc = 16'h0000;           step("R7 eoi clears", 0, 8'h00, 1);
                                 step("R8 idle high", 0, 8'h00, 0);
        oc = 16'h0001;           step("R9 set ch1", 0, 8'h00, 0);
        en = 16'hFFFC;           step("R9 disable ch1", 0, 8'h00, 0);
        en = 16'hFFFD;           step("R9 rearm clears ch1", 0, 8'h00, 0);
        oc = 16'h0010;           step("R10 set ch5", 0, 8'h00, 0);
        inm = 16'h0010;          step("R10 ch5 masked", 0, 8'h00, 0);
        inm = 16'h0030; oc = 16'h0000; step("R10 setup", 0, 8'h00, 0);
        oc = 16'h0020;           step("R10 input channel no record", 0, 8'h00, 0);
        inm = 16'h0000;          step("R10 restored", 0, 8'h00, 0);
        oc = 16'h0000;           step("R11 eoi beats read", 1, 8'h07, 1);
        oc = 16'h0040;           step("R11 not frozen", 0, 8'h00, 0);
        oc = 16'h0000;           step("R7 clear", 0, 8'h00, 1);
                                 step("R8 freeze empty", 1, 8'h07, 0);
        oc = 16'h0200;           step("R8 hold only drives irq", 0, 8'h00, 0);
        oc = 16'h0280;           step("R7 event with eoi", 0, 8'h00, 1);
        en = 16'hFDFD; oc = 16'h0000; step("R9 disable ch10", 0, 8'h00, 0);
        en = 16'hFFFD;           step("R9 rearm ch10", 0, 8'h00, 0);

        @(negedge clk); @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule